// File: doc/BRIEF.md
# Pipelined Data Memory Controller

This block connects a processor's pipelined data interface to a single-port synchronous RAM that is addressed by word. In each cycle the processor presents a byte address, an active-low request flag, a sequential flag and a write flag. The block decodes each cycle into one of four classes. Two of them, a fresh access and a next-word access, reach memory. The other two, an internal cycle and a coprocessor transfer, leave memory alone. Data moves in the cycle after the address is taken, for both reads and writes. When a cycle must be stretched, the block raises a wait output, and the processor holds all of its outputs until wait drops.

A fresh (nonsequential) access always costs one wait state, which stands for opening a new row. A sequential access runs without waits. It uses a predicted address that the block keeps internally: the previous access address plus one word. Because of this, a sequential read can be issued to the RAM in its own address phase without waiting on the processor's address. The block compares the presented address with the prediction and flags a mismatch on a protocol-error output. The RAM has a single port. A sequential read that arrives while a write is finishing cannot share the port, so it takes one wait state.

Top module: `dmem_ctrl`

## Requirements
- R1: The pair {cpu_req_n, cpu_seq} selects the class: 00 nonsequential, 01 sequential, 10 internal, 11 coprocessor. An internal or coprocessor address phase starts no memory access, whatever the write flag says.
- R2: Nonsequential read accepted at edge k: cpu_wait is high for exactly one cycle after k. The RAM read is issued in that wait cycle. cpu_rdata carries the word in the next cycle, when wait is low.
- R3: Nonsequential write accepted at edge k: cpu_wait is high for one cycle. The RAM write to word address cpu_addr[ADDR_W-1:2] uses the cpu_wdata that is present in the following cycle, when wait is low. No memory write ever occurs while cpu_wait is high.
- R4: Sequential read: no wait. The RAM read is issued in the address phase at the predicted word, and cpu_rdata carries the word in the next cycle.
- R5: Sequential write: no wait. The RAM is written at the predicted word in the next cycle, using the cpu_wdata of that cycle.
- R6: A sequential read whose address phase coincides with the completing data phase of a write takes one wait state. The read is then issued in the wait cycle.
- R7: The predicted byte address is 0 after reset. It becomes cpu_addr+4 after a nonsequential access and the prediction plus 4 after a sequential one, and internal and coprocessor cycles leave it unchanged. A sequential cycle whose cpu_addr differs from the prediction, or that has no nonsequential or sequential cycle before it since reset, raises seq_err in the next cycle only, and the access still uses the predicted word.
- R8: A held address phase is taken exactly once. A nonsequential access causes exactly one RAM enable, however long its inputs are held.
- R9: While rst_n is low, and until its synchronized release, cpu_wait, seq_err and mem_en stay low and no request is taken.
- R10: cpu_rdata is zero in every cycle except the cycle in which a read's data completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | ADDR_W | Byte address of the address phase |
| cpu_req_n | input | 1 | Active-low memory request flag |
| cpu_seq | input | 1 | Sequential flag |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_wdata | input | DATA_W | Write data, valid in the data phase |
| cpu_rdata | output | DATA_W | Read data, nonzero only in the completing read cycle |
| cpu_wait | output | 1 | Stretch the data phase; processor holds its outputs |
| seq_err | output | 1 | Sequential address did not match the prediction |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W-2 | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after a read enable |

## Verification
The assertions check several rules on every cycle. A wait never lasts more than one cycle. No memory write happens during a wait. Internal and coprocessor address phases never start a read. seq_err only follows an accepted sequential cycle. Read data stays zero during waits. The three users of the RAM port never collide, and a sequential read that follows a finishing write always produces a wait. Only the bench scenarios can show that data lands at the right word and returns in the right cycle, that the prediction survives idle cycles and reports mismatches, and that a held access reaches the RAM exactly once.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Cycle class, encoded as {req_n, seq}
  typedef enum logic [1:0] {
    CYC_N = 2'b00,
    CYC_S = 2'b01,
    CYC_I = 2'b10,
    CYC_C = 2'b11
  } cyc_e;

  function automatic cyc_e classify(input logic req_n, input logic seq);
    return cyc_e'({req_n, seq});
  endfunction

endpackage

// File: rtl/dmc_rst_sync.sv
module dmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/dmc_cycle_decode.sv
module dmc_cycle_decode
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BYTE_SHIFT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic                         req_n,
  input  logic                         seq,
  input  logic [ADDR_W-1:0]            addr,
  output cyc_e                         cls,
  output logic                         acc_n,
  output logic                         acc_s,
  output logic [ADDR_W-BYTE_SHIFT-1:0] n_word,
  output logic [ADDR_W-BYTE_SHIFT-1:0] s_word,
  output logic                         seq_bad
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BYTE_SHIFT;

  logic [ADDR_W-1:0] pred_q, pred_d;
  logic              have_q, have_d;
  logic              pred_en;

  assign cls     = classify(req_n, seq);
  assign acc_n   = accept && (cls == CYC_N);
  assign acc_s   = accept && (cls == CYC_S);
  assign n_word  = addr[ADDR_W-1:BYTE_SHIFT];
  assign s_word  = pred_q[ADDR_W-1:BYTE_SHIFT];
  assign seq_bad = acc_s && (!have_q || (addr != pred_q));
  assign pred_en = acc_n || acc_s;

  // next-state: burst address predictor
  always_comb begin
    pred_d = pred_q;
    have_d = have_q;
    if (acc_n) begin
      pred_d = addr + STEP;
      have_d = 1'b1;
    end else if (acc_s) begin
      pred_d = pred_q + STEP;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      have_q <= 1'b0;
    end else if (pred_en) begin
      pred_q <= pred_d;
      have_q <= have_d;
    end
  end

  // R7: once any access has been taken, the predictor stays armed
  have_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_q |=> have_q);

endmodule

// File: rtl/dmc_pipe.sv
module dmc_pipe #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_n,
  input  logic              acc_s,
  input  logic              wr,
  input  logic [WORD_W-1:0] n_word,
  input  logic [WORD_W-1:0] s_word,
  input  logic              seq_bad,
  output logic              cpu_wait,
  output logic              seq_err,
  output logic              s_rd_now,
  output logic              held_rd_now,
  output logic              wr_now,
  output logic              rd_done,
  output logic [WORD_W-1:0] dp_word
);

  logic              valid_q, valid_d;
  logic              wr_q, wr_d;
  logic              hold_q, hold_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              err_q;
  logic              load;

  assign cpu_wait    = valid_q && hold_q;
  assign wr_now      = valid_q && wr_q && !hold_q;
  assign rd_done     = valid_q && !wr_q && !hold_q;
  assign held_rd_now = valid_q && hold_q && !wr_q;
  assign s_rd_now    = acc_s && !wr && !wr_now;
  assign load        = acc_n || acc_s;
  assign dp_word     = word_q;
  assign seq_err     = err_q;

  // next-state: data phase tracker
  always_comb begin
    valid_d = valid_q;
    wr_d    = wr_q;
    hold_d  = hold_q;
    word_d  = word_q;
    if (cpu_wait) begin
      hold_d = 1'b0;
    end else if (acc_n) begin
      valid_d = 1'b1;
      wr_d    = wr;
      hold_d  = 1'b1;
      word_d  = n_word;
    end else if (acc_s) begin
      valid_d = 1'b1;
      wr_d    = wr;
      hold_d  = !wr && wr_now;
      word_d  = s_word;
    end else begin
      valid_d = 1'b0;
      hold_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wr_q    <= wr_d;
      hold_q  <= hold_d;
      err_q   <= seq_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_d;
  end

  // R6
  s_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_s && !wr && wr_now) |=> cpu_wait);

  // R2
  one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> !cpu_wait);

endmodule

// File: rtl/dmc_mem_port.sv
module dmc_mem_port #(
  parameter int WORD_W = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_rd_now,
  input  logic [WORD_W-1:0] s_word,
  input  logic              held_rd_now,
  input  logic              wr_now,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] dp_word,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (wr_now) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = dp_word;
      mem_wdata = cpu_wdata;
    end else if (held_rd_now) begin
      mem_en   = 1'b1;
      mem_addr = dp_word;
    end else if (s_rd_now) begin
      mem_en   = 1'b1;
      mem_addr = s_word;
    end
  end

  assign cpu_rdata = rd_done ? mem_rdata : '0;

  // R6: the single RAM port never has two users in one cycle
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_rd_now, held_rd_now, wr_now}));

endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic                         cpu_req_n,
  input  logic                         cpu_seq,
  input  logic                         cpu_wr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         cpu_wait,
  output logic                         seq_err,
  output logic                         mem_en,
  output logic                         mem_we,
  output logic [ADDR_W-3:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata
);

  localparam int BYTE_SHIFT = 2;
  localparam int WORD_W     = ADDR_W - BYTE_SHIFT;

  logic              core_rst_n;
  logic              accept;
  cyc_e              cls;
  logic              acc_n, acc_s, seq_bad;
  logic [WORD_W-1:0] n_word, s_word, dp_word;
  logic              s_rd_now, held_rd_now, wr_now, rd_done;

  dmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(core_rst_n)
  );

  assign accept = core_rst_n && !cpu_wait;

  dmc_cycle_decode #(.ADDR_W(ADDR_W), .BYTE_SHIFT(BYTE_SHIFT)) u_dec (
    .clk(clk), .rst_n(core_rst_n), .accept(accept),
    .req_n(cpu_req_n), .seq(cpu_seq), .addr(cpu_addr),
    .cls(cls), .acc_n(acc_n), .acc_s(acc_s),
    .n_word(n_word), .s_word(s_word), .seq_bad(seq_bad)
  );

  dmc_pipe #(.WORD_W(WORD_W)) u_pipe (
    .clk(clk), .rst_n(core_rst_n),
    .acc_n(acc_n), .acc_s(acc_s), .wr(cpu_wr),
    .n_word(n_word), .s_word(s_word), .seq_bad(seq_bad),
    .cpu_wait(cpu_wait), .seq_err(seq_err),
    .s_rd_now(s_rd_now), .held_rd_now(held_rd_now),
    .wr_now(wr_now), .rd_done(rd_done), .dp_word(dp_word)
  );

  dmc_mem_port #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(core_rst_n),
    .s_rd_now(s_rd_now), .s_word(s_word), .held_rd_now(held_rd_now),
    .wr_now(wr_now), .rd_done(rd_done), .dp_word(dp_word),
    .cpu_wdata(cpu_wdata), .mem_rdata(mem_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata)
  );

  // R1
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (accept && (cls == CYC_I || cls == CYC_C)) |-> !(mem_en && !mem_we));

  // R3
  wr_not_in_wait_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_en && mem_we) |-> !cpu_wait);

  // R7
  seq_err_src_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    seq_err |-> $past(acc_s));

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    cpu_wait |-> (cpu_rdata == '0));

  // R9
  always @(posedge clk) begin
    if (!core_rst_n) begin
      reset_quiet_chk: assert (!cpu_wait && !seq_err && !mem_en);
    end
  end

endmodule

// File: tb/dmem_ctrl_test.sv
module dmem_ctrl_test;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int WW = AW - 2;
  localparam logic [DW-1:0] FILL = 32'hA5A5_A5A5;

  logic          clk, rst_n;
  logic [AW-1:0] cpu_addr;
  logic          cpu_req_n, cpu_seq, cpu_wr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic          cpu_wait, seq_err, mem_en, mem_we;
  logic [WW-1:0] mem_addr;

  dmem_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_req_n(cpu_req_n),
    .cpu_seq(cpu_seq), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .seq_err(seq_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [DW-1:0] ram    [0:(1<<WW)-1];
  logic [DW-1:0] shadow [0:(1<<WW)-1];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  typedef struct { logic [WW-1:0] a; logic [DW-1:0] d; string tag; } wexp_t;
  typedef struct { logic [DW-1:0] d; string tag; } rexp_t;
  wexp_t wq[$];
  rexp_t rq[$];
  wexp_t we_item;
  rexp_t re_item;

  int checks = 0, errors = 0, en_cnt = 0, n0;
  bit rst_done = 0, finished = 0, rd_pend = 0, chk_next = 0;
  bit exp_wait_next = 0, exp_err_next = 0, have = 0, prev_wr = 0;
  logic [AW-1:0] pred = '0;
  logic [DW-1:0] pend_wd = FILL;
  string wait_tag = "R2";

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
    end
  endtask

  // Driver: one address phase, held while wait is high; pushes expectations
  task automatic cyc(input bit rn, input bit sq, input bit w,
                     input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input string tag);
    bit wt;
    logic [WW-1:0] word;
    if (chk_next) begin
      chk(wait_tag, "wait after address phase", cpu_wait, exp_wait_next);
      chk("R7", "seq_err after address phase", seq_err, exp_err_next);
      chk_next = 0;
    end
    cpu_req_n = rn; cpu_seq = sq; cpu_wr = w; cpu_addr = a; cpu_wdata = pend_wd;
    do begin
      wt = cpu_wait;
      @(posedge clk);
      @(negedge clk);
    end while (wt);
    exp_wait_next = 0; exp_err_next = 0; wait_tag = tag;
    if (!rn) begin
      if (!sq) begin
        word = a[AW-1:2];
        exp_wait_next = 1;
        pred = a + 4;
      end else begin
        word = pred[AW-1:2];
        exp_err_next = !have || (a != pred);
        exp_wait_next = !w && prev_wr;
        pred = pred + 4;
      end
      have = 1;
      if (w) begin
        wq.push_back('{word, wd, tag});
        shadow[word] = wd;
        pend_wd = wd;
      end else begin
        rq.push_back('{shadow[word], tag});
        rd_pend = 1;
        pend_wd = FILL;
      end
      prev_wr = w;
    end else begin
      prev_wr = 0;
      pend_wd = FILL;
    end
    chk_next = 1;
  endtask

  // Monitor: compares RAM writes and completed reads against the queues
  always @(negedge clk) begin
    #2;
    if (rst_done && !finished) begin
      if (mem_en) en_cnt++;
      if (mem_en && mem_we) begin
        if (wq.size() == 0) chk("R8", "unexpected RAM write", 1, 0);
        else begin
          we_item = wq.pop_front();
          chk(we_item.tag, "write word address", DW'(mem_addr), DW'(we_item.a));
          chk(we_item.tag, "write data", mem_wdata, we_item.d);
        end
      end
      if (rd_pend && !cpu_wait) begin
        re_item = rq.pop_front();
        chk(re_item.tag, "read data", cpu_rdata, re_item.d);
        rd_pend = 0;
      end else begin
        chk("R10", "read data outside completion", cpu_rdata, '0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1; cpu_req_n = 1; cpu_seq = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < (1 << WW); i++) begin
      ram[i]    = 32'h1000_0000 + i * 3;
      shadow[i] = 32'h1000_0000 + i * 3;
    end
    #1 rst_n = 0;
    @(negedge clk);
    cpu_req_n = 0; cpu_seq = 1;
    repeat (3) begin
      @(negedge clk); #2;
      chk("R9", "wait in reset", cpu_wait, 0);
      chk("R9", "seq_err in reset", seq_err, 0);
      chk("R9", "mem_en in reset", mem_en, 0);
      chk("R9", "rdata in reset", cpu_rdata, 0);
    end
    @(negedge clk);
    cpu_req_n = 1; cpu_seq = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);
    rst_done = 1;

    // R7: sequential with no prior access, reads predicted word 0
    cyc(0, 1, 0, 10'h008, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R1");
    // R2 then R4
    cyc(0, 0, 0, 10'h040, 0, "R2");
    cyc(0, 1, 0, 10'h044, 0, "R4");
    cyc(0, 1, 0, 10'h048, 0, "R4");
    cyc(1, 0, 0, 0, 0, "R1");
    // R3 and R5 with read-back
    cyc(0, 0, 1, 10'h080, 32'h1111_0001, "R3");
    cyc(0, 1, 1, 10'h084, 32'h2222_0002, "R5");
    cyc(0, 0, 0, 10'h080, 0, "R3");
    cyc(0, 1, 0, 10'h084, 0, "R5");
    cyc(1, 0, 0, 0, 0, "R1");
    // R6: sequential read right after a write
    cyc(0, 0, 1, 10'h100, 32'h3333_0003, "R3");
    cyc(0, 1, 0, 10'h104, 0, "R6");
    cyc(0, 1, 1, 10'h108, 32'h4444_0004, "R5");
    cyc(0, 1, 0, 10'h10C, 0, "R6");
    cyc(0, 0, 0, 10'h108, 0, "R5");
    cyc(1, 0, 0, 0, 0, "R1");
    // R7: mismatch, recovery, prediction kept across internal and coprocessor
    cyc(0, 0, 0, 10'h020, 0, "R7");
    cyc(0, 1, 0, 10'h030, 0, "R7");
    cyc(0, 1, 0, 10'h028, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R7");
    cyc(1, 1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 10'h02C, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R1");
    // R1: internal and coprocessor cycles, with and without write flag
    n0 = en_cnt;
    cyc(1, 0, 1, 10'h050, 32'hDEAD_0001, "R1");
    cyc(1, 1, 0, 10'h054, 0, "R1");
    cyc(1, 1, 1, 10'h058, 32'hDEAD_0002, "R1");
    cyc(1, 0, 0, 10'h05C, 0, "R1");
    #3 chk("R1", "RAM enables during internal/coprocessor", en_cnt - n0, 0);
    @(negedge clk);
    // R8: a held nonsequential access reaches the RAM once
    n0 = en_cnt;
    cyc(0, 0, 0, 10'h090, 0, "R8");
    cyc(1, 0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, 0, "R8");
    #3 chk("R8", "RAM enables for one held read", en_cnt - n0, 1);
    @(negedge clk);
    n0 = en_cnt;
    cyc(0, 0, 1, 10'h094, 32'h5555_0005, "R8");
    cyc(1, 0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, 0, "R8");
    #3 chk("R8", "RAM enables for one held write", en_cnt - n0, 1);
    @(negedge clk);
    cyc(0, 0, 0, 10'h094, 0, "R3");
    cyc(1, 0, 0, 0, 0, "R1");
    cyc(1, 0, 0, 0, 0, "R1");
    #3;
    chk("R8", "writes left unperformed", wq.size(), 0);
    chk("R8", "reads left unreturned", rq.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule